// File: doc/BRIEF.md
# Per-CPU Bus Interrupt Mailbox

This block gives each CPU of a cluster a one-deep mailbox for interrupt messages that arrive from a system bus. A message names a target CPU and carries a 5-bit source ID and two 64-bit data words. If the target's mailbox is free, the block latches the source and both words and answers with an accept in the same cycle. One cycle later it raises an interrupt post to that CPU. The post carries a single shared 6-bit vector. If the mailbox is occupied, the message is refused and the sender retries later.

CPUs reach the mailboxes through a simple register port. Data words and the busy status can be read by explicit index, or through "self" alias addresses that resolve to the entry of the requesting CPU. Writing a busy status register loads the busy flag from bit 5. Writing 0 frees the mailbox. Each mailbox is a two-state machine:

- States: `MB_FREE` and `MB_BUSY`.
- Transition ACCEPT (`MB_FREE` to `MB_BUSY`): a message is taken.
- Transition SEIZE (`MB_FREE` to `MB_BUSY`): software writes busy = 1.
- Transition RELEASE (`MB_BUSY` to `MB_FREE`): software writes busy = 0.

Register byte map (12-bit address, bits 2:0 must be zero):

| Address | Register |
|---|---|
| 0x000 + 8·n | Data word 0 of CPU n |
| 0x100 + 8·n | Data word 1 of CPU n |
| 0x200 + 8·n | Busy status of CPU n |
| 0x300 | Own data word 0 |
| 0x308 | Own data word 1 |
| 0x310 | Own busy status |
| 0x318 | Shared vector |

Top module: `cpu_irq_mailbox`

## Requirements
- R1: After reset every busy flag, source ID, data word, the shared vector, `reg_rdata` and `post_valid` are zero.
- R2: `msg_accept` is high in the same cycle as `msg_valid` when the target mailbox is free and no busy-status write to that CPU occurs in that cycle. A busy mailbox of another CPU has no effect on the decision.
- R3: An accepted message sets the target's busy flag and stores its source ID and both data words. These are visible through register reads issued from the next cycle on.
- R4: In the cycle after an accept, `post_valid` is high for exactly one cycle. In that cycle `post_cpu` is the target and `post_vec` is the shared vector as it was at the accept. Without an accept, `post_valid` stays low.
- R5: A message to a busy mailbox gets `msg_accept` low. It causes no post, and the stored source and data stay unchanged.
- R6: Writing 0x318 loads the shared vector from `reg_wdata[5:0]`. Reading 0x318 returns it zero-extended.
- R7: A busy status read returns the busy flag in bit 5 and the source ID in bits 4:0, combined by OR, with all other bits zero.
- R8: A busy status write loads the flag from `reg_wdata[5]`. Writing 0 frees the mailbox (RELEASE), and writing 1 marks it busy (SEIZE). Neither changes the stored source ID.
- R9: The indexed windows select entry n = (byte offset − window base) >> 3. The bases are 0x000 for data word 0, 0x100 for data word 1 and 0x200 for busy status.
- R10: The alias addresses 0x300, 0x308 and 0x310 select the entry of the CPU given on `reg_cpu`.
- R11: When a RELEASE write and a message for the same CPU arrive in one cycle, the write takes effect and the message is refused in that cycle. The same message held for one more cycle is accepted.
- R12: `reg_rdata` is registered: it shows the addressed value in the cycle after `reg_rd` and holds otherwise. Unmapped, misaligned or out-of-range indexed reads return 0, and writes to data windows change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Incoming message present |
| msg_cpu | input | CPU_W | Target CPU of the message |
| msg_src | input | 5 | Source ID of the message |
| msg_d0 | input | DATA_W | Data word 0 of the message |
| msg_d1 | input | DATA_W | Data word 1 of the message |
| msg_accept | output | 1 | Message taken this cycle (combinational) |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_cpu | input | CPU_W | ID of the requesting CPU, used by the alias addresses |
| reg_wdata | input | 6 | Register write data (vector bits, busy in bit 5) |
| reg_rdata | output | DATA_W | Registered read data |
| post_valid | output | 1 | Interrupt post pulse |
| post_cpu | output | CPU_W | CPU receiving the post |
| post_vec | output | 6 | Vector delivered with the post |

## Verification
`msg_accept` is combinational. The bench samples it 1 ns after driving a message, still inside the cycle in which it is presented.

Mailbox state, the vector register, the post outputs and `reg_rdata` each sit one register away from their stimulus. Their values are compared at the falling edge that follows the rising edge which captured the stimulus.

For the collision case, the refusal is checked in the cycle of the write. The acceptance is checked one cycle later, with the message still held. Every read is issued one cycle and checked at the next falling edge, so no check races an update.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int ADDR_W   = 12;
    localparam int SRC_W    = 5;
    localparam int VEC_W    = 6;
    localparam int BUSY_BIT = 5;
    localparam int IDX_W    = 5;

    localparam logic [1:0] RGN_DATA0 = 2'd0;
    localparam logic [1:0] RGN_DATA1 = 2'd1;
    localparam logic [1:0] RGN_BUSY  = 2'd2;
    localparam logic [1:0] RGN_MISC  = 2'd3;

    localparam logic [7:0] OFS_SELF_D0   = 8'h00;
    localparam logic [7:0] OFS_SELF_D1   = 8'h08;
    localparam logic [7:0] OFS_SELF_BUSY = 8'h10;
    localparam logic [7:0] OFS_VECTOR    = 8'h18;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_DATA0,
        RK_DATA1,
        RK_BUSY,
        RK_VEC
    } reg_kind_e;

    typedef enum logic {
        MB_FREE,
        MB_BUSY
    } mb_state_e;
endpackage

// File: rtl/mbx_reg_decode.sv
module mbx_reg_decode
    import mbx_pkg::*;
#(
    parameter int NUM_CPU = 4,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CPU_W-1:0]  req_cpu,
    output reg_kind_e         kind,
    output logic [CPU_W-1:0]  idx
);
    logic [IDX_W-1:0] raw_idx;
    logic             aligned;
    logic             in_range;

    assign raw_idx  = addr[7:3];
    assign aligned  = (addr[2:0] == 3'b000) && (addr[ADDR_W-1:10] == '0);
    assign in_range = {1'b0, raw_idx} < (IDX_W+1)'(NUM_CPU);

    always_comb begin
        kind = RK_NONE;
        idx  = raw_idx[CPU_W-1:0];
        if (aligned) begin
            unique case (addr[9:8])
                RGN_DATA0: if (in_range) kind = RK_DATA0;
                RGN_DATA1: if (in_range) kind = RK_DATA1;
                RGN_BUSY:  if (in_range) kind = RK_BUSY;
                RGN_MISC: begin
                    idx = req_cpu;
                    unique case (addr[7:0])
                        OFS_SELF_D0:   kind = RK_DATA0;
                        OFS_SELF_D1:   kind = RK_DATA1;
                        OFS_SELF_BUSY: kind = RK_BUSY;
                        OFS_VECTOR:    kind = RK_VEC;
                        default:       kind = RK_NONE;
                    endcase
                end
                default: kind = RK_NONE;
            endcase
        end
    end
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot
    import mbx_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [SRC_W-1:0]  src_in,
    input  logic [DATA_W-1:0] d0_in,
    input  logic [DATA_W-1:0] d1_in,
    input  logic              busy_wr,
    input  logic              busy_val,
    output logic              busy,
    output logic [SRC_W-1:0]  src_q,
    output logic [DATA_W-1:0] d0_q,
    output logic [DATA_W-1:0] d1_q
);
    mb_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= MB_FREE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            MB_FREE: begin
                if (take)                     state_nx = MB_BUSY;  // ACCEPT
                else if (busy_wr && busy_val) state_nx = MB_BUSY;  // SEIZE
            end
            MB_BUSY: begin
                if (busy_wr && !busy_val)     state_nx = MB_FREE;  // RELEASE
            end
            default: state_nx = MB_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            d0_q  <= '0;
            d1_q  <= '0;
        end else if (take) begin
            src_q <= src_in;
            d0_q  <= d0_in;
            d1_q  <= d1_in;
        end
    end

    assign busy = (state == MB_BUSY);

    // R5: a message is only ever steered into a free mailbox
    a_r5_take_only_free: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> state == MB_FREE);
    // R11: write and message never both land on this slot in one cycle
    a_r11_write_blocks_take: assert property (@(posedge clk) disable iff (!rst_n)
        busy_wr |-> !take);
    a_r3_take_stores: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> busy && src_q == $past(src_in) && d0_q == $past(d0_in)
                 && d1_q == $past(d1_in));
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        busy_wr && !busy_val |=> !busy && $stable(src_q));
    a_r8_seize: assert property (@(posedge clk) disable iff (!rst_n)
        busy_wr && busy_val |=> busy && $stable(src_q));
    a_r5_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !busy_wr |=> busy && $stable(src_q) && $stable(d0_q) && $stable(d1_q));
endmodule

// File: rtl/mbx_post.sv
module mbx_post
    import mbx_pkg::*;
#(
    parameter int CPU_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [CPU_W-1:0] cpu_in,
    input  logic [VEC_W-1:0] vec_in,
    output logic             post_valid,
    output logic [CPU_W-1:0] post_cpu,
    output logic [VEC_W-1:0] post_vec
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            post_valid <= 1'b0;
            post_cpu   <= '0;
            post_vec   <= '0;
        end else begin
            post_valid <= fire;
            if (fire) begin
                post_cpu <= cpu_in;
                post_vec <= vec_in;
            end
        end
    end
endmodule

// File: rtl/cpu_irq_mailbox.sv
module cpu_irq_mailbox
    import mbx_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int DATA_W  = 64,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic [CPU_W-1:0]  msg_cpu,
    input  logic [SRC_W-1:0]  msg_src,
    input  logic [DATA_W-1:0] msg_d0,
    input  logic [DATA_W-1:0] msg_d1,
    output logic              msg_accept,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CPU_W-1:0]  reg_cpu,
    input  logic [VEC_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              post_valid,
    output logic [CPU_W-1:0]  post_cpu,
    output logic [VEC_W-1:0]  post_vec
);
    reg_kind_e        kind;
    logic [CPU_W-1:0] idx;
    logic [VEC_W-1:0] vec_q;
    logic [DATA_W-1:0] rd_nx;

    logic [NUM_CPU-1:0] busy_a;
    logic [NUM_CPU-1:0] take_a;
    logic [NUM_CPU-1:0] bwr_a;
    logic [SRC_W-1:0]   src_a [NUM_CPU];
    logic [DATA_W-1:0]  d0_a  [NUM_CPU];
    logic [DATA_W-1:0]  d1_a  [NUM_CPU];

    mbx_reg_decode #(.NUM_CPU(NUM_CPU)) u_dec (
        .addr    (reg_addr),
        .req_cpu (reg_cpu),
        .kind    (kind),
        .idx     (idx)
    );

    logic tgt_ok;
    assign tgt_ok     = {1'b0, msg_cpu} < (CPU_W+1)'(NUM_CPU);
    assign msg_accept = msg_valid && tgt_ok && !busy_a[msg_cpu] && !bwr_a[msg_cpu];

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_slot
        assign take_a[g] = msg_accept && (msg_cpu == CPU_W'(g));
        assign bwr_a[g]  = reg_wr && (kind == RK_BUSY) && (idx == CPU_W'(g));

        mbx_slot #(.DATA_W(DATA_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .take     (take_a[g]),
            .src_in   (msg_src),
            .d0_in    (msg_d0),
            .d1_in    (msg_d1),
            .busy_wr  (bwr_a[g]),
            .busy_val (reg_wdata[BUSY_BIT]),
            .busy     (busy_a[g]),
            .src_q    (src_a[g]),
            .d0_q     (d0_a[g]),
            .d1_q     (d1_a[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                          vec_q <= '0;
        else if (reg_wr && kind == RK_VEC)   vec_q <= reg_wdata;
    end

    always_comb begin
        rd_nx = '0;
        unique case (kind)
            RK_DATA0: rd_nx = d0_a[idx];
            RK_DATA1: rd_nx = d1_a[idx];
            RK_BUSY:  rd_nx = (DATA_W'(busy_a[idx]) << BUSY_BIT) | DATA_W'(src_a[idx]);
            RK_VEC:   rd_nx = DATA_W'(vec_q);
            default:  rd_nx = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_nx;
    end

    mbx_post #(.CPU_W(CPU_W)) u_post (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (msg_accept),
        .cpu_in     (msg_cpu),
        .vec_in     (vec_q),
        .post_valid (post_valid),
        .post_cpu   (post_cpu),
        .post_vec   (post_vec)
    );

    a_r4_post_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        msg_accept |=> post_valid && post_cpu == $past(msg_cpu) && post_vec == $past(vec_q));
    a_r4_no_spurious_post: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_accept |=> !post_valid);
    a_r6_vector_load: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && kind == RK_VEC |=> vec_q == $past(reg_wdata));
    a_r12_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
    a_r2_one_take: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take_a));
endmodule

// File: tb/cpu_irq_mailbox_test.sv
module cpu_irq_mailbox_test;
    localparam int NUM_CPU = 4;
    localparam int DATA_W  = 64;
    localparam int CPU_W   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              msg_valid = 1'b0;
    logic [CPU_W-1:0]  msg_cpu = '0;
    logic [4:0]        msg_src = '0;
    logic [DATA_W-1:0] msg_d0 = '0;
    logic [DATA_W-1:0] msg_d1 = '0;
    logic              msg_accept;
    logic              reg_rd = 1'b0;
    logic              reg_wr = 1'b0;
    logic [11:0]       reg_addr = '0;
    logic [CPU_W-1:0]  reg_cpu = '0;
    logic [5:0]        reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              post_valid;
    logic [CPU_W-1:0]  post_cpu;
    logic [5:0]        post_vec;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cpu_irq_mailbox #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .msg_valid(msg_valid), .msg_cpu(msg_cpu), .msg_src(msg_src),
        .msg_d0(msg_d0), .msg_d1(msg_d1), .msg_accept(msg_accept),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_cpu(reg_cpu), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .post_valid(post_valid), .post_cpu(post_cpu), .post_vec(post_vec)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, input logic [1:0] cpu, output logic [63:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a; reg_cpu = cpu;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [11:0] a, input logic [1:0] cpu, input logic [5:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_cpu = cpu; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic send(input logic [1:0] cpu, input logic [4:0] src,
                        input logic [63:0] d0, input logic [63:0] d1,
                        input bit exp_acc, input logic [5:0] exp_vec, input string req);
        @(negedge clk);
        msg_valid = 1'b1; msg_cpu = cpu; msg_src = src; msg_d0 = d0; msg_d1 = d1;
        #1;
        chk({req, " accept"}, 64'(msg_accept), 64'(exp_acc));
        @(negedge clk);
        msg_valid = 1'b0;
        chk("R4 post_valid", 64'(post_valid), 64'(exp_acc));
        if (exp_acc) begin
            chk("R4 post_cpu", 64'(post_cpu), 64'(cpu));
            chk("R4 post_vec", 64'(post_vec), 64'(exp_vec));
        end
    endtask

    task automatic t_reset();
        logic [63:0] v;
        chk("R1 post_valid", 64'(post_valid), 64'd0);
        chk("R1 rdata", reg_rdata, 64'd0);
        for (int i = 0; i < NUM_CPU; i++) begin
            rd(12'h200 + 12'(i * 8), 2'd0, v);
            chk("R1 busy status", v, 64'd0);
        end
        rd(12'h318, 2'd0, v); chk("R1 vector", v, 64'd0);
        rd(12'h110, 2'd0, v); chk("R1 data word", v, 64'd0);
    endtask

    task automatic t_vector();
        logic [63:0] v;
        wr(12'h318, 2'd0, 6'h2B);
        rd(12'h318, 2'd3, v); chk("R6 vector readback", v, 64'h2B);
    endtask

    task automatic t_accept();
        logic [63:0] v;
        send(2'd1, 5'h13, 64'hA5A5_0001_DEAD_BEEF, 64'h0123_4567_89AB_CDEF, 1'b1, 6'h2B, "R2");
        rd(12'h008, 2'd0, v); chk("R3 R9 data0 idx1", v, 64'hA5A5_0001_DEAD_BEEF);
        rd(12'h108, 2'd0, v); chk("R3 R9 data1 idx1", v, 64'h0123_4567_89AB_CDEF);
        rd(12'h208, 2'd0, v); chk("R7 busy status idx1", v, 64'h33);
        rd(12'h000, 2'd0, v); chk("R9 data0 idx0 untouched", v, 64'd0);
    endtask

    task automatic t_reject();
        logic [63:0] v;
        send(2'd1, 5'h07, 64'h1111, 64'h2222, 1'b0, 6'h0, "R5");
        rd(12'h008, 2'd0, v); chk("R5 data0 kept", v, 64'hA5A5_0001_DEAD_BEEF);
        rd(12'h208, 2'd0, v); chk("R5 source kept", v, 64'h33);
        wr(12'h318, 2'd0, 6'h05);
        send(2'd3, 5'h1F, 64'h3333, 64'h4444, 1'b1, 6'h05, "R2 other cpu");
        rd(12'h218, 2'd0, v); chk("R7 busy idx3", v, 64'h3F);
    endtask

    task automatic t_alias();
        logic [63:0] v;
        rd(12'h300, 2'd1, v); chk("R10 self data0 cpu1", v, 64'hA5A5_0001_DEAD_BEEF);
        rd(12'h308, 2'd3, v); chk("R10 self data1 cpu3", v, 64'h4444);
        rd(12'h310, 2'd1, v); chk("R10 self busy cpu1", v, 64'h33);
        rd(12'h310, 2'd0, v); chk("R10 self busy cpu0", v, 64'h0);
    endtask

    task automatic t_release_seize();
        logic [63:0] v;
        wr(12'h208, 2'd0, 6'h00);
        rd(12'h208, 2'd0, v); chk("R8 release keeps source", v, 64'h13);
        wr(12'h200, 2'd2, 6'h20);
        rd(12'h200, 2'd0, v); chk("R8 seize", v, 64'h20);
        send(2'd0, 5'h01, 64'h5, 64'h6, 1'b0, 6'h0, "R8 seized rejects");
        wr(12'h310, 2'd0, 6'h1F);
        rd(12'h200, 2'd0, v); chk("R8 alias write bit5=0 frees", v, 64'h0);
    endtask

    task automatic t_collide();
        logic [63:0] v;
        send(2'd1, 5'h0A, 64'hCAFE, 64'hF00D, 1'b1, 6'h05, "R2 refill");
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 12'h310; reg_cpu = 2'd1; reg_wdata = 6'h00;
        msg_valid = 1'b1; msg_cpu = 2'd1; msg_src = 5'h0C; msg_d0 = 64'h77; msg_d1 = 64'h88;
        #1;
        chk("R11 refused during release", 64'(msg_accept), 64'd0);
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R11 no post", 64'(post_valid), 64'd0);
        #1;
        chk("R11 accepted next cycle", 64'(msg_accept), 64'd1);
        @(negedge clk);
        msg_valid = 1'b0;
        chk("R11 post", 64'(post_valid), 64'd1);
        rd(12'h008, 2'd0, v); chk("R11 new data stored", v, 64'h77);
    endtask

    task automatic t_misc();
        logic [63:0] v;
        rd(12'h3F8, 2'd0, v); chk("R12 unmapped", v, 64'd0);
        rd(12'h020, 2'd0, v); chk("R12 index out of range", v, 64'd0);
        rd(12'h00C, 2'd0, v); chk("R12 misaligned", v, 64'd0);
        wr(12'h008, 2'd0, 6'h3F);
        rd(12'h008, 2'd0, v); chk("R12 data write ignored", v, 64'h77);
        @(negedge clk);
        chk("R12 rdata holds", reg_rdata, 64'h77);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_vector();
        t_accept();
        t_reject();
        t_alias();
        t_release_seize();
        t_collide();
        t_misc();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule